// File: doc/BRIEF.md
# Memory Operand Access Fault Checker

This block screens every memory operand access and every instruction fetch before the access goes out. A request strobe presents the access: its offset, its size, whether it is a fetch, whether it uses the stack segment, the operating mode, the current privilege level, the alignment-check flag, the length of the current instruction and which processor generation applies. One clock later the block returns a single-cycle fault flag and the exception vector that the core must raise.

It detects three kinds of fault. The first is an instruction that exceeds the generation's length limit. The second is a real-mode access that runs past the top of its 64 KiB segment, which includes a fetch that wraps to offset zero. The third is a misaligned data access made at privilege 3 while alignment checking is on. The core uses the result to abort the access and to dispatch the handler. Descriptor-based protection checks and paging are handled elsewhere.

Top module: `mem_fault_check`

## Requirements
- R1: After reset, and until the first request is registered, `fault_o` is 0 and `vector_o` is 8'h00.
- R2: `fault_o` is 1 for exactly the one cycle after a clock edge at which `req_i` was 1 and a fault condition held. In a cycle that follows an edge with `req_i` at 0, `fault_o` is 0.
- R3: In real mode (`real_mode_i`=1), an access overruns when its last byte lies beyond offset FFFFh: a word (`size_i`=01) at FFFFh, or a dword (`size_i`=10) at FFFDh or above. If the access is a data access (`fetch_i`=0) in the stack segment (`stack_seg_i`=1), the overrun reports vector 8'h0C.
- R4: A real-mode data overrun outside the stack segment reports vector 8'h0D.
- R5: A real-mode fetch (`fetch_i`=1) that wraps past FFFFh reports vector 8'h0D, whatever the value of `stack_seg_i`.
- R6: In protected mode (`real_mode_i`=0), no segment overrun fault is raised.
- R7: An instruction length `insn_len_i` greater than 10 when `gen_new_i`=0, or greater than 15 when `gen_new_i`=1, reports vector 8'h0D. A length equal to the limit raises no fault.
- R8: An alignment fault with vector 8'h11 is raised only for a data access when `ac_flag_i`=1, `cpl_i`=3 and the access is misaligned. A word is misaligned at an odd offset. A dword is misaligned when `offset_i[1:0]` is not 0. Fetches never raise an alignment fault.
- R9: A byte access (`size_i`=00, and the reserved code 11, which is treated as a byte) never raises an overrun fault or an alignment fault.
- R10: When several faults apply at once, the length fault wins, then the overrun fault, then the alignment fault.
- R11: `vector_o` is 8'h00 in every cycle in which `fault_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| offset_i | input | OFF_W (16) | Access offset within its segment |
| size_i | input | 2 | 00 byte, 01 word, 10 dword, 11 treated as byte |
| fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| stack_seg_i | input | 1 | 1 = access uses the stack segment |
| real_mode_i | input | 1 | 1 = real mode, 0 = protected mode |
| cpl_i | input | 2 | Current privilege level |
| ac_flag_i | input | 1 | Alignment-check flag |
| insn_len_i | input | LEN_W (5) | Length of the current instruction in bytes |
| gen_new_i | input | 1 | 1 = newer generation (limit 15), 0 = older (limit 10) |
| fault_o | output | 1 | Fault flag, registered, one cycle |
| vector_o | output | 8 | Exception vector, 00h when there is no fault |

## Verification
The bench targets the overrun boundaries exactly: a word at FFFEh against FFFFh, and a dword at FFFCh against FFFDh. An off-by-one end computation shows up there as a missing fault or a spurious one. It drives fetches and data accesses in the stack segment side by side. A design that chose the vector from the segment class alone would report 0Ch for a wrapping fetch. Instruction lengths equal to the limit and one above it, under both generations, expose a comparison that uses the wrong limit or is off by one. Accesses that qualify for several faults at once show whether the priority order is wrong. Random traffic biased toward the top of the segment, with privilege 3 and alignment checking mixed in, catches gating mistakes. These include alignment faults at privilege 0 and faults on byte accesses.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } acc_size_e;

  localparam logic [7:0] VEC_NONE  = 8'h00;
  localparam logic [7:0] VEC_STACK = 8'h0C;
  localparam logic [7:0] VEC_GP    = 8'h0D;
  localparam logic [7:0] VEC_ALIGN = 8'h11;

  // bytes beyond the first touched by an access
  function automatic logic [1:0] extra_bytes(acc_size_e sz);
    case (sz)
      SZ_WORD:  return 2'd1;
      SZ_DWORD: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/mfc_len_chk.sv
module mfc_len_chk #(
  parameter int LEN_W   = 5,
  parameter int OLD_MAX = 10,
  parameter int NEW_MAX = 15
) (
  input  logic [LEN_W-1:0] insn_len_i,
  input  logic             gen_new_i,
  output logic             too_long_o
);
  localparam logic [LEN_W-1:0] OldLim = LEN_W'(OLD_MAX);
  localparam logic [LEN_W-1:0] NewLim = LEN_W'(NEW_MAX);

  logic [LEN_W-1:0] lim;
  assign lim        = gen_new_i ? NewLim : OldLim;
  assign too_long_o = insn_len_i > lim;
endmodule

// File: rtl/mfc_overrun_chk.sv
module mfc_overrun_chk
  import mfc_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic [OFF_W-1:0] offset_i,
  input  acc_size_e        size_i,
  input  logic             real_mode_i,
  output logic             overrun_o
);
  logic [OFF_W:0] last_byte;

  // carry out of the segment offset space marks an overrun
  assign last_byte = {1'b0, offset_i} + (OFF_W+1)'(extra_bytes(size_i));
  assign overrun_o = real_mode_i & last_byte[OFF_W];
endmodule

// File: rtl/mfc_align_chk.sv
module mfc_align_chk
  import mfc_pkg::*;
(
  input  logic [1:0] off_lo_i,
  input  acc_size_e  size_i,
  input  logic       fetch_i,
  input  logic       ac_flag_i,
  input  logic [1:0] cpl_i,
  output logic       misalign_o
);
  logic bad_addr;

  always_comb begin
    case (size_i)
      SZ_WORD:  bad_addr = off_lo_i[0];
      SZ_DWORD: bad_addr = |off_lo_i;
      default:  bad_addr = 1'b0;
    endcase
  end

  assign misalign_o = bad_addr & ac_flag_i & (cpl_i == 2'd3) & ~fetch_i;
endmodule

// File: rtl/mem_fault_check.sv
module mem_fault_check
  import mfc_pkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int LEN_W   = 5,
  parameter int OLD_MAX = 10,
  parameter int NEW_MAX = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [1:0]       size_i,
  input  logic             fetch_i,
  input  logic             stack_seg_i,
  input  logic             real_mode_i,
  input  logic [1:0]       cpl_i,
  input  logic             ac_flag_i,
  input  logic [LEN_W-1:0] insn_len_i,
  input  logic             gen_new_i,
  output logic             fault_o,
  output logic [7:0]       vector_o
);
  acc_size_e  size;
  logic       too_long, overrun, misalign;
  logic       fault_d;
  logic [7:0] vec_d;
  logic       fault_q;
  logic [7:0] vec_q;

  assign size = acc_size_e'(size_i);

  mfc_len_chk #(
    .LEN_W  (LEN_W),
    .OLD_MAX(OLD_MAX),
    .NEW_MAX(NEW_MAX)
  ) u_len (
    .insn_len_i(insn_len_i),
    .gen_new_i (gen_new_i),
    .too_long_o(too_long)
  );

  mfc_overrun_chk #(.OFF_W(OFF_W)) u_ovr (
    .offset_i   (offset_i),
    .size_i     (size),
    .real_mode_i(real_mode_i),
    .overrun_o  (overrun)
  );

  mfc_align_chk u_aln (
    .off_lo_i  (offset_i[1:0]),
    .size_i    (size),
    .fetch_i   (fetch_i),
    .ac_flag_i (ac_flag_i),
    .cpl_i     (cpl_i),
    .misalign_o(misalign)
  );

  // priority: length, overrun, alignment
  always_comb begin
    fault_d = 1'b0;
    vec_d   = VEC_NONE;
    if (req_i) begin
      if (too_long) begin
        fault_d = 1'b1;
        vec_d   = VEC_GP;
      end else if (overrun) begin
        fault_d = 1'b1;
        vec_d   = (stack_seg_i && !fetch_i) ? VEC_STACK : VEC_GP;
      end else if (misalign) begin
        fault_d = 1'b1;
        vec_d   = VEC_ALIGN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      vec_q   <= VEC_NONE;
    end else begin
      fault_q <= fault_d;
      vec_q   <= vec_d;
    end
  end

  assign fault_o  = fault_q;
  assign vector_o = vec_q;
endmodule

// File: rtl/mfc_fault_chk.sv
module mfc_fault_chk #(
  parameter int OFF_W   = 16,
  parameter int LEN_W   = 5,
  parameter int OLD_MAX = 10,
  parameter int NEW_MAX = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [OFF_W-1:0] offset_i,
  input logic [1:0]       size_i,
  input logic             fetch_i,
  input logic             real_mode_i,
  input logic [LEN_W-1:0] insn_len_i,
  input logic             gen_new_i,
  input logic             fault_o,
  input logic [7:0]       vector_o
);
  logic [LEN_W-1:0] lim;
  assign lim = gen_new_i ? LEN_W'(NEW_MAX) : LEN_W'(OLD_MAX);

  // R2
  no_req_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !fault_o);

  // R11
  quiet_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> vector_o == 8'h00);

  // R7
  len_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && insn_len_i > lim |=> fault_o && vector_o == 8'h0D);

  // R6
  prot_no_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !real_mode_i |=> vector_o != 8'h0C);

  // R9
  byte_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (size_i == 2'b00 || size_i == 2'b11) && insn_len_i <= lim |=> !fault_o);

  // R5
  fetch_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && fetch_i |=> vector_o != 8'h0C && vector_o != 8'h11);

  // R3
  word_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && real_mode_i && size_i == 2'b01 && offset_i == '1 |=> fault_o);
endmodule

bind mem_fault_check mfc_fault_chk #(
  .OFF_W  (OFF_W),
  .LEN_W  (LEN_W),
  .OLD_MAX(OLD_MAX),
  .NEW_MAX(NEW_MAX)
) u_fault_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .offset_i   (offset_i),
  .size_i     (size_i),
  .fetch_i    (fetch_i),
  .real_mode_i(real_mode_i),
  .insn_len_i (insn_len_i),
  .gen_new_i  (gen_new_i),
  .fault_o    (fault_o),
  .vector_o   (vector_o)
);

// File: tb/mem_fault_check_bench.sv
module mem_fault_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] off = '0;
  logic [1:0]  sz = '0;
  logic        fetch = 1'b0, stk = 1'b0, rm = 1'b0, ac = 1'b0, gnew = 1'b0;
  logic [1:0]  cpl = '0;
  logic [4:0]  len = 5'd1;
  logic        fault;
  logic [7:0]  vec;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mem_fault_check u_mem_fault_check (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .offset_i(off), .size_i(sz),
    .fetch_i(fetch), .stack_seg_i(stk), .real_mode_i(rm), .cpl_i(cpl),
    .ac_flag_i(ac), .insn_len_i(len), .gen_new_i(gnew),
    .fault_o(fault), .vector_o(vec)
  );

  function automatic logic [8:0] ref_out(logic r, logic [15:0] o, logic [1:0] s,
      logic f, logic st, logic m, logic [1:0] c, logic a, logic [4:0] l, logic g);
    int nb, lim;
    logic mis;
    if (!r) return 9'h000;
    lim = g ? 15 : 10;
    if (int'(l) > lim) return {1'b1, 8'h0D};
    nb = (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
    if (m && (int'(o) + nb - 1) > 65535) return {1'b1, (f || !st) ? 8'h0D : 8'h0C};
    mis = (s == 2'b01 && o[0]) || (s == 2'b10 && o[1:0] != 2'b00);
    if (!f && a && c == 2'd3 && mis) return {1'b1, 8'h11};
    return 9'h000;
  endfunction

  task automatic check(string tag, logic [8:0] exp);
    total++;
    if ({fault, vec} !== exp) begin
      bad++;
      $display("FAIL %s: got fault=%0b vec=%02h, want fault=%0b vec=%02h",
               tag, fault, vec, exp[8], exp[7:0]);
    end
  endtask

  task automatic apply(string tag, logic r, logic [15:0] o, logic [1:0] s, logic f,
      logic st, logic m, logic [1:0] c, logic a, logic [4:0] l, logic g);
    logic [8:0] exp;
    req = r; off = o; sz = s; fetch = f; stk = st; rm = m; cpl = c; ac = a; len = l; gnew = g;
    exp = ref_out(r, o, s, f, st, m, c, a, l, g);
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 9'h000);

    // R3 / R4 boundaries
    apply("R3 stack word FFFF", 1, 16'hFFFF, 2'b01, 0, 1, 1, 0, 0, 5'd2, 0);
    apply("R2 single cycle", 0, 16'hFFFF, 2'b01, 0, 1, 1, 0, 0, 5'd2, 0);
    apply("R3 stack word FFFE ok", 1, 16'hFFFE, 2'b01, 0, 1, 1, 0, 0, 5'd2, 0);
    apply("R3 stack dword FFFD", 1, 16'hFFFD, 2'b10, 0, 1, 1, 0, 0, 5'd2, 0);
    apply("R3 stack dword FFFC ok", 1, 16'hFFFC, 2'b10, 0, 1, 1, 0, 0, 5'd2, 0);
    apply("R4 data dword FFFE", 1, 16'hFFFE, 2'b10, 0, 0, 1, 0, 0, 5'd2, 0);
    apply("R4 data word FFFF", 1, 16'hFFFF, 2'b01, 0, 0, 1, 0, 0, 5'd2, 0);
    // R5
    apply("R5 fetch wrap stack", 1, 16'hFFFF, 2'b10, 1, 1, 1, 0, 0, 5'd3, 0);
    // R6
    apply("R6 protected no overrun", 1, 16'hFFFF, 2'b10, 0, 1, 0, 0, 0, 5'd3, 0);
    // R7
    apply("R7 old len 10 ok", 1, 16'h0010, 2'b00, 0, 0, 1, 0, 0, 5'd10, 0);
    apply("R7 old len 11", 1, 16'h0010, 2'b00, 0, 0, 1, 0, 0, 5'd11, 0);
    apply("R7 new len 15 ok", 1, 16'h0010, 2'b00, 0, 0, 0, 0, 0, 5'd15, 1);
    apply("R7 new len 16", 1, 16'h0010, 2'b00, 0, 0, 0, 0, 0, 5'd16, 1);
    // R8
    apply("R8 word odd cpl3", 1, 16'h0101, 2'b01, 0, 0, 0, 2'd3, 1, 5'd2, 1);
    apply("R8 word odd cpl0", 1, 16'h0101, 2'b01, 0, 0, 0, 2'd0, 1, 5'd2, 1);
    apply("R8 word odd no ac", 1, 16'h0101, 2'b01, 0, 0, 0, 2'd3, 0, 5'd2, 1);
    apply("R8 dword off2", 1, 16'h0102, 2'b10, 0, 0, 0, 2'd3, 1, 5'd2, 1);
    apply("R8 dword aligned", 1, 16'h0104, 2'b10, 0, 0, 0, 2'd3, 1, 5'd2, 1);
    apply("R8 fetch exempt", 1, 16'h0103, 2'b10, 1, 0, 0, 2'd3, 1, 5'd2, 1);
    // R9
    apply("R9 byte FFFF", 1, 16'hFFFF, 2'b00, 0, 1, 1, 2'd3, 1, 5'd2, 0);
    apply("R9 rsvd size FFFF", 1, 16'hFFFF, 2'b11, 0, 0, 1, 2'd3, 1, 5'd2, 0);
    // R10
    apply("R10 len over overrun", 1, 16'hFFFF, 2'b01, 0, 1, 1, 2'd3, 1, 5'd12, 0);
    apply("R10 overrun over align", 1, 16'hFFFF, 2'b01, 0, 1, 1, 2'd3, 1, 5'd2, 0);
    apply("R11 no fault vector", 1, 16'h0200, 2'b01, 0, 0, 1, 2'd3, 1, 5'd2, 0);

    // random traffic, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] o;
      o = ($urandom % 2) ? (16'hFFF8 | 16'($urandom % 8)) : 16'($urandom);
      apply("R10 random", 1'($urandom % 4 != 0), o, 2'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
            5'($urandom % 18), 1'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule